// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block decides, for each transmit channel of a bus transceiver, whether the line driver may be enabled. It watches the transmit-data level that the protocol controller supplies. If that level asks for a dominant bit without a break for longer than a set number of clock cycles, the guard withdraws the driver enable, which lets the bus fall back to recessive. The enable comes back only when the transmit input has returned high. A controller that hangs or crashes with its transmit pin low therefore cannot hold the whole network dominant.

A shared overtemperature flag turns off the drivers of every channel at once. Each channel keeps its own lock after the flag drops and clears it only after it sees its own transmit input high. Waiting for a recessive input stops the driver from oscillating as the temperature drifts around the threshold. The driver is also held off whenever the channel is not in normal mode. All channels are identical and share nothing except the overtemperature input. The time-out length is a parameter in clock cycles. It must be longer than the longest legal dominant run at the lowest supported bit rate, 40 kbit/s.

Top module: `txg_guard_top`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `drv_en` is 0. The dominant counters and overtemperature locks start cleared.
- R2: A transmit input is dominant when its effective level is 0. The effective level is `tx_level | tx_float`. With normal mode on and no overtemperature lock, `drv_en` stays 1 through a dominant run of up to TIMEOUT_CYC consecutive clock samples. It goes to 0 one clock after the sample numbered TIMEOUT_CYC+1 of that run.
- R3: Once a channel has timed out, its `drv_en` stays 0 for as long as the input stays dominant. The first sample with the input high clears the counter and re-enables the driver on the following clock. This holds only if normal mode is on and the channel has no lock. A high sample of any length restarts the count from zero.
- R4: The dominant counter saturates. A dominant run of any length, however much longer than TIMEOUT_CYC, never re-enables the driver.
- R5: When `norm_mode[i]` is 0, `drv_en[i]` is 0 one clock later. The mode input does not affect the time-out count.
- R6: When `overtemp` is 1, every bit of `drv_en` is 0 one clock later.
- R7: After `overtemp` returns to 0, a channel stays disabled until its own effective transmit level is sampled high. That sample must come with `overtemp` at 0. Each channel recovers on its own.
- R8: A channel whose `tx_float` bit is 1 is treated as recessive. The flag clears that channel's counter and can release its overtemperature lock.
- R9: The channels are independent. A time-out, lock or mode change on one channel leaves the enable of another channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_level | input | NUM_CH | Synchronized transmit data per channel, 1 = recessive, 0 = dominant |
| tx_float | input | NUM_CH | Per channel: the transmit input is undefined or floating (treated as recessive) |
| norm_mode | input | NUM_CH | Per channel: 1 = normal mode, 0 = standby |
| overtemp | input | 1 | Shared overtemperature flag |
| drv_en | output | NUM_CH | Registered driver enable per channel; 0 releases the bus to recessive |

## Verification
The bench goes after the exact edge of the time-out. It checks a dominant run of exactly TIMEOUT_CYC samples, which must keep the driver on, and then one more sample, which must turn it off. A design off by one in either direction fails one of these two checks. Holding the input low for several times the limit shows up a counter that wraps, because such a counter would turn the driver back on by itself. Dropping the overtemperature flag while one channel is still dominant and the other is already recessive shows up two faults. A design that re-enables on the flag alone fails here, and so does a design that shares one lock between the channels. Long random runs, including floating-input and standby episodes, compare every cycle against a bench model.

// File: rtl/txg_pkg.sv
package txg_pkg;

  // Per-channel input bundle routed from the top to each channel slice.
  typedef struct packed {
    logic tx_level;  // 1 = recessive
    logic tx_float;  // input reported undefined
    logic norm;      // channel in normal mode
  } txg_ch_in_t;

  // Counter width able to hold the value 'limit'.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_high,
  output logic expired
);
  localparam int CW = txg_pkg::cnt_width(TIMEOUT_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  // Counts consecutive dominant samples; holds at LIMIT, clears on recessive.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tx_high) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LIMIT);

  // R3: a recessive sample empties the counter
  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
    tx_high |=> (cnt_q == '0));

  // R4: once expired, a continued dominant input keeps it expired (no wrap)
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (expired && !tx_high) |=> expired);

endmodule

// File: rtl/txg_ot_latch.sv
module txg_ot_latch (
  input  logic clk,
  input  logic rst,
  input  logic overtemp,
  input  logic tx_high,
  output logic hold
);
  logic lock_q;

  // Lock is set by the flag and released only by a recessive sample once the flag is gone.
  assign hold = overtemp | (lock_q & ~tx_high);

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= hold;
  end

  // R7: without a recessive sample the lock survives the flag dropping
  p_lock_keep_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(overtemp) && !overtemp && !tx_high) |-> hold);

endmodule

// File: rtl/txg_channel.sv
module txg_channel
  import txg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  txg_ch_in_t ch_in,
  input  logic       overtemp,
  output logic       drv_en
);
  logic tx_eff;
  logic expired;
  logic hold;
  logic drv_en_q;

  assign tx_eff = ch_in.tx_level | ch_in.tx_float;

  txg_dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .tx_high (tx_eff),
    .expired (expired)
  );

  txg_ot_latch i_ot (
    .clk      (clk),
    .rst      (rst),
    .overtemp (overtemp),
    .tx_high  (tx_eff),
    .hold     (hold)
  );

  always_ff @(posedge clk) begin
    if (rst) drv_en_q <= 1'b0;
    else     drv_en_q <= ch_in.norm & ~hold & ~(expired & ~tx_eff);
  end

  assign drv_en = drv_en_q;

  // R2: a dominant sample past the limit removes the enable
  p_timeout_off_r2: assert property (@(posedge clk) disable iff (rst)
    (expired && !tx_eff) |=> !drv_en_q);

  // R3: recessive input in normal mode without overtemperature enables
  p_recover_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_eff && ch_in.norm && !overtemp) |=> drv_en_q);

  // R5: standby keeps the driver off
  p_standby_off_r5: assert property (@(posedge clk) disable iff (rst)
    !ch_in.norm |=> !drv_en_q);

  // R7: a held lock with dominant input keeps the driver off
  p_wait_high_r7: assert property (@(posedge clk) disable iff (rst)
    (hold && !tx_eff) |=> !drv_en_q);

  // R8: floating input counts as recessive
  p_float_high_r8: assert property (@(posedge clk) disable iff (rst)
    (ch_in.tx_float && ch_in.norm && !overtemp) |=> drv_en_q);

endmodule

// File: rtl/txg_guard_top.sv
module txg_guard_top
  import txg_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tx_level,
  input  logic [NUM_CH-1:0] tx_float,
  input  logic [NUM_CH-1:0] norm_mode,
  input  logic              overtemp,
  output logic [NUM_CH-1:0] drv_en
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    txg_ch_in_t ch_in;
    assign ch_in.tx_level = tx_level[g];
    assign ch_in.tx_float = tx_float[g];
    assign ch_in.norm     = norm_mode[g];

    txg_channel #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_chan (
      .clk      (clk),
      .rst      (rst),
      .ch_in    (ch_in),
      .overtemp (overtemp),
      .drv_en   (drv_en[g])
    );
  end

  // R6: overtemperature disables every channel
  p_ot_all_off_r6: assert property (@(posedge clk) disable iff (rst)
    overtemp |=> (drv_en == '0));

  // R1: the first cycle after reset shows all drivers off
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (drv_en == '0));

endmodule

// File: tb/test_txg_guard_top.sv
`timescale 1ns/1ps
module test_txg_guard_top;
  localparam int N  = 2;
  localparam int TO = 40;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] tx_level, tx_float, norm_mode;
  logic         overtemp;
  logic [N-1:0] drv_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int   m_cnt  [N];
  logic m_lock [N];
  logic m_en   [N];

  always #2 clk = ~clk;

  txg_guard_top #(.NUM_CH(N), .TIMEOUT_CYC(TO)) i_txg_guard_top (
    .clk(clk), .rst(rst), .tx_level(tx_level), .tx_float(tx_float),
    .norm_mode(norm_mode), .overtemp(overtemp), .drv_en(drv_en)
  );

  // Expected enable from R2..R8 given the sampled inputs and model state.
  function automatic logic exp_en(input int cnt, input logic lock, input logic eff,
                                  input logic nm, input logic ot);
    logic held;
    held = ot | (lock & ~eff);
    return nm & ~held & ~(~eff & (cnt >= TO));
  endfunction

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_cnt[c] = 0; m_lock[c] = 1'b0; m_en[c] = 1'b0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < N; c++) begin
      logic eff;
      eff      = tx_level[c] | tx_float[c];
      m_en[c]  = exp_en(m_cnt[c], m_lock[c], eff, norm_mode[c], overtemp);
      m_lock[c] = overtemp | (m_lock[c] & ~eff);
      m_cnt[c] = eff ? 0 : ((m_cnt[c] >= TO) ? TO : m_cnt[c] + 1);
    end
  endtask

  task automatic step(input logic [N-1:0] tx, input logic [N-1:0] fl,
                      input logic [N-1:0] nm, input logic ot);
    @(negedge clk);
    tx_level = tx; tx_float = fl; norm_mode = nm; overtemp = ot;
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic chk(input int c, input logic exp, input string req);
    checks++;
    if (drv_en[c] !== exp) begin
      errors++;
      $display("FAIL %s ch%0d: drv_en actual %b expected %b", req, c, drv_en[c], exp);
    end
  endtask

  task automatic chk_model(input string req);
    for (int c = 0; c < N; c++) chk(c, m_en[c], req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; tx_level = '1; tx_float = '0; norm_mode = '1; overtemp = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(0, 1'b0, "R1"); chk(1, 1'b0, "R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); model_step(); #1;
    chk_model("R1");

    // R2 boundary: exactly TO dominant samples keep the enable
    for (int i = 0; i < TO; i++) step(2'b10, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b1, "R2"); chk(1, 1'b1, "R9");
    step(2'b10, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b0, "R2"); chk(1, 1'b1, "R9");
    // R4: long dominant never re-enables
    for (int i = 0; i < 5 * TO; i++) begin
      step(2'b10, 2'b00, 2'b11, 1'b0);
      if (i % 37 == 0) chk(0, 1'b0, "R4");
    end
    chk(0, 1'b0, "R4");
    // R3: recessive sample releases
    step(2'b11, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b1, "R3");
    // R3: short high pulse restarts count
    for (int i = 0; i < TO - 5; i++) step(2'b10, 2'b00, 2'b11, 1'b0);
    step(2'b11, 2'b00, 2'b11, 1'b0);
    for (int i = 0; i < TO; i++) step(2'b10, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b1, "R3");
    step(2'b11, 2'b00, 2'b11, 1'b0);

    // R6 / R7
    step(2'b11, 2'b00, 2'b11, 1'b1);
    chk(0, 1'b0, "R6"); chk(1, 1'b0, "R6");
    step(2'b10, 2'b00, 2'b11, 1'b1);
    step(2'b10, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b0, "R7"); chk(1, 1'b1, "R7");
    step(2'b10, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b0, "R7");
    step(2'b11, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b1, "R7");

    // R5 standby
    step(2'b11, 2'b00, 2'b10, 1'b0);
    chk(0, 1'b0, "R5"); chk(1, 1'b1, "R9");
    step(2'b11, 2'b00, 2'b11, 1'b0);
    chk(0, 1'b1, "R5");

    // R8 floating input treated as recessive
    for (int i = 0; i < 3 * TO; i++) step(2'b00, 2'b01, 2'b11, 1'b0);
    chk(0, 1'b1, "R8"); chk(1, 1'b0, "R2");
    step(2'b00, 2'b01, 2'b11, 1'b1);
    step(2'b00, 2'b01, 2'b11, 1'b0);
    chk(0, 1'b1, "R8");
    step(2'b11, 2'b00, 2'b11, 1'b0);
    chk_model("R3");

    // Random phase against the model
    begin
      logic [N-1:0] tx, fl, nm;
      logic ot;
      tx = '1; fl = '0; nm = '1; ot = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        for (int c = 0; c < N; c++) begin
          if ($urandom % 55 == 0) tx[c] = ~tx[c];
          if ($urandom % 250 == 0) nm[c] = ~nm[c];
          fl[c] = (fl[c] && ($urandom % 8 != 0)) || ($urandom % 300 == 0);
        end
        if (ot) ot = ($urandom % 15 != 0);
        else    ot = ($urandom % 400 == 0);
        step(tx, fl, nm, ot);
        chk_model("R9");
      end
    end
    finish_run();
  end
endmodule